// File: doc/BRIEF.md
# Dual-Port Semaphore Token Bank

A bank of eight hardware semaphore latches shared by a left and a right port. The latches are separate from any data storage. Software on either side claims a shared resource by writing 0 to one semaphore and gives it back by writing 1. It then reads the same semaphore to learn whether it holds the token. Each latch remembers a request from each side as well as the current owner. A request made by the side that does not own the token therefore waits, and it is granted in the same cycle the owner lets go.

Each port has a semaphore select, a memory chip enable, a write strobe, an address, a write data bus and a registered read data bus. The block works on the lowest three address bits and on write data bit 0 only. A read returns the ownership of that port on every data line. The value is held in a per-port output register until the same port reads again. If both sides request a free token in the same cycle, the left port always wins.

Top module: `sema_bank`

## Requirements
- R1: After reset all eight semaphores are free and no requests are pending. A read of any semaphore from either port returns all ones, and both read registers hold all ones while reset is active.
- R2: The semaphore is chosen by address bits [2:0] alone. Every higher address bit has no effect on which semaphore is read or written.
- R3: A read returns 0 when the reading port owns the semaphore and 1 when it does not, copied onto all DATA_W lines. A read presented before a rising edge is captured at that edge and reflects the state before any write taken at the same edge.
- R4: A write (write strobe 1) uses only data bit 0. A value of 0 is a request and a value of 1 is a release or cancel. All other data bits are ignored.
- R5: A request to a free semaphore makes the requesting side the owner. The requester then reads 0 and the other side reads 1.
- R6: A request by the side that does not own the semaphore leaves ownership unchanged and is recorded as pending.
- R7: When the owner writes 1 and the other side has a request pending, ownership passes to the other side at that same edge. With no request pending the semaphore becomes free, and both sides read 1.
- R8: A write of 1 by a side that does not own the semaphore cancels its own pending request. A later release by the owner then leaves the semaphore free.
- R9: When both sides request a free semaphore at the same edge, the left port becomes owner. The right request stays pending and is granted when the left releases.
- R10: A read register changes only when its own port performs a read. Writes by either port and idle cycles leave it unchanged.
- R11: A port takes part in semaphore access only when its select is 1 and its chip enable is 0. With the select at 1 and the chip enable at 1, or with the select at 0, the port changes no semaphore and captures no read.
- R12: The eight semaphores are independent. An access to one semaphore leaves the ownership and pending requests of all others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left semaphore select, active high |
| l_ce | input | 1 | Left memory chip enable, active high; blocks semaphore access |
| l_wr | input | 1 | Left write strobe: 1 write, 0 read |
| l_adr | input | ADDR_W | Left address; bits [2:0] pick the semaphore |
| l_wdata | input | DATA_W | Left write data; bit 0 used |
| l_rdata | output | DATA_W | Left registered read value |
| r_sel | input | 1 | Right semaphore select, active high |
| r_ce | input | 1 | Right memory chip enable, active high; blocks semaphore access |
| r_wr | input | 1 | Right write strobe: 1 write, 0 read |
| r_adr | input | ADDR_W | Right address; bits [2:0] pick the semaphore |
| r_wdata | input | DATA_W | Right write data; bit 0 used |
| r_rdata | output | DATA_W | Right registered read value |

## Verification
A write presented in one cycle updates ownership at the next rising edge. A read presented in the following cycle therefore sees that write. A read result appears on the read bus one edge after the read is presented, and it stays there until that port reads again. The driver applies each access at the falling edge and queues the expected word for each read. The monitor pops and compares the word a quarter period after the rising edge that captures the read. The hold checks sample the read bus one full idle cycle after the disturbing write.

// File: rtl/sema_pkg.sv
package sema_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // Request bit after an optional write: data 0 asks, data 1 withdraws.
    function automatic logic next_req(input logic cur, input logic wen, input logic wbit);
        return wen ? ~wbit : cur;
    endfunction

    // Ownership after the request bits of this edge are known.
    function automatic owner_e next_owner(input owner_e cur, input logic want_l, input logic want_r);
        owner_e nxt;
        case (cur)
            OWN_LEFT:  nxt = want_l ? OWN_LEFT  : (want_r ? OWN_RIGHT : OWN_NONE);
            OWN_RIGHT: nxt = want_r ? OWN_RIGHT : (want_l ? OWN_LEFT  : OWN_NONE);
            default:   nxt = want_l ? OWN_LEFT  : (want_r ? OWN_RIGHT : OWN_NONE);
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/sema_port_dec.sv
module sema_port_dec #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 18,
    parameter int NSEM   = 8
) (
    input  logic                      sel,
    input  logic                      ce,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         adr,
    input  logic [DATA_W-1:0]         wdata,
    output logic [NSEM-1:0]           wsel,
    output logic                      wbit,
    output logic                      rd,
    output logic [$clog2(NSEM)-1:0]   ridx
);
    localparam int IDX_W = $clog2(NSEM);

    logic active;
    logic unused_bits;

    assign active = sel & ~ce;
    assign rd     = active & ~wr;
    assign ridx   = adr[IDX_W-1:0];
    assign wbit   = wdata[0];

    genvar g;
    generate
        for (g = 0; g < NSEM; g++) begin : g_wsel
            assign wsel[g] = active & wr & (adr[IDX_W-1:0] == IDX_W'(g));
        end
    endgenerate

    assign unused_bits = ^{wdata[DATA_W-1:1], adr[ADDR_W-1:IDX_W]};

endmodule

// File: rtl/sema_cell.sv
module sema_cell
    import sema_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wen_l,
    input  logic wbit_l,
    input  logic wen_r,
    input  logic wbit_r,
    output logic owns_l,
    output logic owns_r,
    output logic req_l,
    output logic req_r
);
    owner_e own_q, own_n;
    logic   rl_q, rr_q, rl_n, rr_n;

    always_comb begin
        rl_n  = next_req(rl_q, wen_l, wbit_l);
        rr_n  = next_req(rr_q, wen_r, wbit_r);
        own_n = next_owner(own_q, rl_n, rr_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q <= OWN_NONE;
            rl_q  <= 1'b0;
            rr_q  <= 1'b0;
        end else begin
            own_q <= own_n;
            rl_q  <= rl_n;
            rr_q  <= rr_n;
        end
    end

    assign owns_l = (own_q == OWN_LEFT);
    assign owns_r = (own_q == OWN_RIGHT);
    assign req_l  = rl_q;
    assign req_r  = rr_q;

endmodule

// File: rtl/sema_rdport.sv
module sema_rdport #(
    parameter int DATA_W = 18,
    parameter int NSEM   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd,
    input  logic [$clog2(NSEM)-1:0]  ridx,
    input  logic [NSEM-1:0]          not_mine,
    output logic [DATA_W-1:0]        rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '1;
        end else if (rd) begin
            rdata <= {DATA_W{not_mine[ridx]}};
        end
    end
endmodule

// File: rtl/sema_bank.sv
module sema_bank #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 18,
    parameter int NSEM   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel,
    input  logic              l_ce,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_adr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_ce,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_adr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int IDX_W = $clog2(NSEM);

    logic [NSEM-1:0]  l_wsel, r_wsel;
    logic             l_wbit, r_wbit;
    logic             l_rd, r_rd;
    logic [IDX_W-1:0] l_ridx, r_ridx;
    logic [NSEM-1:0]  owns_l, owns_r, req_l, req_r;

    sema_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSEM(NSEM)) u_dec_l (
        .sel(l_sel), .ce(l_ce), .wr(l_wr), .adr(l_adr), .wdata(l_wdata),
        .wsel(l_wsel), .wbit(l_wbit), .rd(l_rd), .ridx(l_ridx)
    );

    sema_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSEM(NSEM)) u_dec_r (
        .sel(r_sel), .ce(r_ce), .wr(r_wr), .adr(r_adr), .wdata(r_wdata),
        .wsel(r_wsel), .wbit(r_wbit), .rd(r_rd), .ridx(r_ridx)
    );

    genvar g;
    generate
        for (g = 0; g < NSEM; g++) begin : g_cell
            sema_cell u_cell (
                .clk(clk), .rst(rst),
                .wen_l(l_wsel[g]), .wbit_l(l_wbit),
                .wen_r(r_wsel[g]), .wbit_r(r_wbit),
                .owns_l(owns_l[g]), .owns_r(owns_r[g]),
                .req_l(req_l[g]), .req_r(req_r[g])
            );
        end
    endgenerate

    sema_rdport #(.DATA_W(DATA_W), .NSEM(NSEM)) u_rd_l (
        .clk(clk), .rst(rst), .rd(l_rd), .ridx(l_ridx),
        .not_mine(~owns_l), .rdata(l_rdata)
    );

    sema_rdport #(.DATA_W(DATA_W), .NSEM(NSEM)) u_rd_r (
        .clk(clk), .rst(rst), .rd(r_rd), .ridx(r_ridx),
        .not_mine(~owns_r), .rdata(r_rdata)
    );

endmodule

// File: rtl/sema_bank_chk.sv
module sema_bank_chk #(
    parameter int DATA_W = 18,
    parameter int NSEM   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              l_sel,
    input logic              l_ce,
    input logic              l_wr,
    input logic              r_sel,
    input logic              r_ce,
    input logic              r_wr,
    input logic [DATA_W-1:0] l_rdata,
    input logic [DATA_W-1:0] r_rdata,
    input logic [NSEM-1:0]   l_wsel,
    input logic [NSEM-1:0]   r_wsel,
    input logic              l_wbit,
    input logic              r_wbit,
    input logic [NSEM-1:0]   owns_l,
    input logic [NSEM-1:0]   owns_r,
    input logic [NSEM-1:0]   req_l,
    input logic [NSEM-1:0]   req_r
);
    AST_LRD_REPLICATED: assert property (@(posedge clk) disable iff (rst)
        (l_rdata == '0) || (l_rdata == '1)); // R3
    AST_RRD_REPLICATED: assert property (@(posedge clk) disable iff (rst)
        (r_rdata == '0) || (r_rdata == '1)); // R3
    AST_LRD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(l_sel && !l_ce && !l_wr) |=> $stable(l_rdata)); // R10
    AST_RRD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(r_sel && !r_ce && !r_wr) |=> $stable(r_rdata)); // R10
    AST_LBLOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (l_ce || !l_sel) |-> (l_wsel == '0)); // R11
    AST_RBLOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (r_ce || !r_sel) |-> (r_wsel == '0)); // R11
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0(l_wsel) && $onehot0(r_wsel)); // R2

    genvar g;
    generate
        for (g = 0; g < NSEM; g++) begin : g_sem
            AST_OWNER_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
                (!owns_l[g] || req_l[g]) && (!owns_r[g] || req_r[g])); // R6
            AST_UNTOUCHED_STABLE: assert property (@(posedge clk) disable iff (rst)
                (!l_wsel[g] && !r_wsel[g]) |=> ($stable(owns_l[g]) && $stable(owns_r[g]))); // R12
            AST_TIE_TO_LEFT: assert property (@(posedge clk) disable iff (rst)
                (!owns_l[g] && !owns_r[g] && l_wsel[g] && !l_wbit) |=> owns_l[g]); // R9
            AST_LEFT_KEEPS: assert property (@(posedge clk) disable iff (rst)
                (owns_l[g] && !(l_wsel[g] && l_wbit)) |=> owns_l[g]); // R6
            AST_RIGHT_KEEPS: assert property (@(posedge clk) disable iff (rst)
                (owns_r[g] && !(r_wsel[g] && r_wbit)) |=> owns_r[g]); // R6
            AST_HANDOFF_RIGHT: assert property (@(posedge clk) disable iff (rst)
                (owns_l[g] && l_wsel[g] && l_wbit && req_r[g] && !r_wsel[g]) |=> owns_r[g]); // R7
        end
    endgenerate
endmodule

bind sema_bank sema_bank_chk #(.DATA_W(DATA_W), .NSEM(NSEM)) u_chk (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_ce(l_ce), .l_wr(l_wr),
    .r_sel(r_sel), .r_ce(r_ce), .r_wr(r_wr),
    .l_rdata(l_rdata), .r_rdata(r_rdata),
    .l_wsel(l_wsel), .r_wsel(r_wsel),
    .l_wbit(l_wbit), .r_wbit(r_wbit),
    .owns_l(owns_l), .owns_r(owns_r),
    .req_l(req_l), .req_r(req_r)
);

// File: tb/sim_sema_bank.sv
module sim_sema_bank;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 14;
    localparam int DATA_W = 18;
    localparam int NSEM   = 8;
    localparam int IDXW   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_sel = 0, l_ce = 0, l_wr = 0, r_sel = 0, r_ce = 0, r_wr = 0;
    logic [ADDR_W-1:0] l_adr = '0, r_adr = '0;
    logic [DATA_W-1:0] l_wdata = '0, r_wdata = '0;
    logic [DATA_W-1:0] l_rdata, r_rdata;

    // staged inputs, applied by step()
    logic s_lsel, s_lce, s_lwr, s_rsel, s_rce, s_rwr;
    logic [ADDR_W-1:0] s_ladr, s_radr;
    logic [DATA_W-1:0] s_ldat, s_rdat;

    logic  ql[$];
    string qlt[$];
    logic  qr[$];
    string qrt[$];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sema_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSEM(NSEM)) u0 (
        .clk(clk), .rst(rst),
        .l_sel(l_sel), .l_ce(l_ce), .l_wr(l_wr), .l_adr(l_adr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_ce(r_ce), .r_wr(r_wr), .r_adr(r_adr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    function automatic logic [ADDR_W-1:0] mk_adr(input int idx, input logic [ADDR_W-1:0] junk);
        logic [ADDR_W-1:0] a;
        a = junk;
        a[IDXW-1:0] = idx[IDXW-1:0];
        return a;
    endfunction

    task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_stage();
        s_lsel = 0; s_lce = 0; s_lwr = 0; s_ladr = '0; s_ldat = '0;
        s_rsel = 0; s_rce = 0; s_rwr = 0; s_radr = '0; s_rdat = '0;
    endtask

    task automatic lw(input int idx, input logic [DATA_W-1:0] d, input logic [ADDR_W-1:0] junk = '0);
        s_lsel = 1; s_lce = 0; s_lwr = 1; s_ladr = mk_adr(idx, junk); s_ldat = d;
    endtask
    task automatic rw(input int idx, input logic [DATA_W-1:0] d, input logic [ADDR_W-1:0] junk = '0);
        s_rsel = 1; s_rce = 0; s_rwr = 1; s_radr = mk_adr(idx, junk); s_rdat = d;
    endtask
    task automatic lr(input int idx, input logic e, input string tag, input logic [ADDR_W-1:0] junk = '0);
        s_lsel = 1; s_lce = 0; s_lwr = 0; s_ladr = mk_adr(idx, junk); s_ldat = '0;
        ql.push_back(e); qlt.push_back(tag);
    endtask
    task automatic rr(input int idx, input logic e, input string tag, input logic [ADDR_W-1:0] junk = '0);
        s_rsel = 1; s_rce = 0; s_rwr = 0; s_radr = mk_adr(idx, junk); s_rdat = '0;
        qr.push_back(e); qrt.push_back(tag);
    endtask

    task automatic step();
        @(negedge clk);
        l_sel = s_lsel; l_ce = s_lce; l_wr = s_lwr; l_adr = s_ladr; l_wdata = s_ldat;
        r_sel = s_rsel; r_ce = s_rce; r_wr = s_rwr; r_adr = s_radr; r_wdata = s_rdat;
        clear_stage();
    endtask

    // monitor: pops the expected word for every read captured at a rising edge
    initial begin
        forever begin
            @(posedge clk);
            begin
                logic lrd, rrd;
                lrd = !rst && l_sel && !l_ce && !l_wr;
                rrd = !rst && r_sel && !r_ce && !r_wr;
                #(CLK_PERIOD/4);
                if (lrd) begin
                    if (ql.size() == 0) chk("left read without expectation", l_rdata, 'x);
                    else chk({"left ", qlt.pop_front()}, l_rdata, {DATA_W{ql.pop_front()}});
                end
                if (rrd) begin
                    if (qr.size() == 0) chk("right read without expectation", r_rdata, 'x);
                    else chk({"right ", qrt.pop_front()}, r_rdata, {DATA_W{qr.pop_front()}});
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear_stage();
        repeat (3) @(negedge clk);
        chk("R1 left reg in reset", l_rdata, '1);
        chk("R1 right reg in reset", r_rdata, '1);
        @(negedge clk);
        rst = 0;

        // R1: all free after reset
        for (int i = 0; i < NSEM; i++) begin
            lr(i, 1'b1, "R1 free after reset");
            rr(i, 1'b1, "R1 free after reset");
            step();
        end

        // R5 / R2: left claims sem 3 with junk upper address bits
        lw(3, '0, 14'h2A50); step();
        lr(3, 1'b0, "R5 requester owns");
        rr(3, 1'b1, "R2 R5 other side not owner", 14'h1FF8); step();

        // R6: right request is pending only
        rw(3, '0); step();
        lr(3, 1'b0, "R6 owner unchanged");
        rr(3, 1'b1, "R6 pending not owner"); step();

        // R10: left register holds 0 across right write and idle
        rw(3, '0); step();
        step();
        chk("R10 left reg held across right write", l_rdata, '0);

        // R11: read with chip enable active is not captured
        s_lsel = 1; s_lce = 1; s_lwr = 0; s_ladr = mk_adr(0, '0); step();
        step();
        chk("R11 blocked read not captured", l_rdata, '0);

        // R7: left release hands token to pending right
        lw(3, 18'h00001); step();
        lr(3, 1'b1, "R7 handoff left view");
        rr(3, 1'b0, "R7 handoff right view"); step();

        // R10: right register unaffected by left write
        lw(3, '0); step();
        step();
        chk("R10 right reg held across left write", r_rdata, '0);

        // R7: right release hands back to pending left
        rw(3, 18'h00001); step();
        lr(3, 1'b0, "R7 handoff back left view");
        rr(3, 1'b1, "R7 handoff back right view"); step();

        // R4: only bit 0 of write data matters
        lw(5, 18'h3FFFE); step();
        lr(5, 1'b0, "R4 bit0 zero requests");
        rr(5, 1'b1, "R4 other side"); step();
        lw(5, 18'h00001); step();
        lr(5, 1'b1, "R4 R7 release to free left");
        rr(5, 1'b1, "R4 R7 release to free right"); step();

        // R8: non-owner cancel
        lw(1, '0); step();
        rw(1, '0); step();
        rw(1, 18'h2AAAB); step();
        lr(1, 1'b0, "R8 owner after cancel");
        rr(1, 1'b1, "R8 canceller not owner"); step();
        lw(1, 18'h00001); step();
        lr(1, 1'b1, "R8 free after cancel left");
        rr(1, 1'b1, "R8 free after cancel right"); step();

        // R9: simultaneous request goes left, right waits
        lw(6, '0); rw(6, '0); step();
        lr(6, 1'b0, "R9 tie left wins");
        rr(6, 1'b1, "R9 tie right loses"); step();
        lw(6, 18'h00001); step();
        lr(6, 1'b1, "R9 left released");
        rr(6, 1'b0, "R9 right granted"); step();

        // R11: blocked writes do nothing
        s_lsel = 1; s_lce = 1; s_lwr = 1; s_ladr = mk_adr(7, '0); s_ldat = '0;
        s_rsel = 0; s_rce = 0; s_rwr = 1; s_radr = mk_adr(7, '0); s_rdat = '0;
        step();
        lr(7, 1'b1, "R11 blocked write left");
        rr(7, 1'b1, "R11 unselected write right"); step();

        // R12: other semaphores unaffected
        lr(3, 1'b0, "R12 sem3 kept left");
        rr(6, 1'b0, "R12 sem6 kept right"); step();
        lr(2, 1'b1, "R12 sem2 free");
        rr(3, 1'b1, "R12 sem3 right view"); step();

        step(); step();
        done = 1;
        if (ql.size() != 0 || qr.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R3 reads not returned actual=%0d expected=0", ql.size() + qr.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule